// File: doc/BRIEF.md
# Write-behind line cache with drain handshake

This block keeps a copy of a fixed, contiguous window of a slower external memory in a small on-chip array. When reset is released it loads that window by reading every word of it over a request/acknowledge port. Only after the load does it serve clients. Clients address the array by line index. A read returns data on the next cycle. A write lands in the array at once and marks the line dirty.

A background writer steps through the line indices in round-robin order. Whenever the external port is free and the line under its pointer is dirty, it sends that line back to external memory. A line's dirty flag is cleared only when its write-back is acknowledged, and only if no newer client write reached the line while the write-back was in flight.

Before a reset of the surrounding logic that must leave external memory intact, the owner raises `drain`. The block then stalls clients and keeps writing back until no dirty line remains. It then raises `drain_done`, which stays high until `drain` falls.

Top module: `wb_line_cache`

## Requirements
- R1: After reset `busy` is high. The block reads the window addresses `BASE`, `BASE+1`, ... `BASE+LINES-1` in ascending order, one read per acknowledge, and issues no external write before the last read is acknowledged.
- R2: `busy` falls on the cycle after the last preload acknowledge (with `drain` low), and client reads then return the preloaded words.
- R3: A client request is taken on a rising edge where `host_req` is high and `busy` is low. A read raises `host_rvalid` for exactly the following cycle, with the line's current word. A write is visible to a read accepted on the next cycle.
- R4: A line written by a client is written to external address `BASE + index` without any drain request, once the external port has served it.
- R5: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged on the next cycle.
- R6: While `drain` is high, `busy` is high. `drain_done` rises only when every line's newest client data has been acknowledged by external memory.
- R7: `drain_done` stays high as long as `drain` stays high, and is low on the cycle after a cycle with `drain` low.
- R8: If a client writes a line whose write-back is in flight, the line stays dirty and the newer word is written to external memory again.
- R9: Requests presented while `busy` is high are ignored. A write does not change the array, and a read raises no `host_rvalid`.
- R10: When no line is dirty, the block raises no external request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts a new preload |
| drain | input | 1 | Request to write back every dirty line and stall clients |
| busy | output | 1 | High during preload and while `drain` is high; clients are stalled |
| drain_done | output | 1 | High once no dirty line remains during a drain, until `drain` falls |
| host_req | input | 1 | Client request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_idx | input | $clog2(LINES) | Line index inside the window |
| host_wdata | input | DATA_W | Write word |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| host_rdata | output | DATA_W | Read word |
| mem_req | output | 1 | External request, held until acknowledged |
| mem_we | output | 1 | 1 = external write, 0 = external read |
| mem_addr | output | MEM_AW | External word address |
| mem_wdata | output | DATA_W | External write word |
| mem_ack | input | 1 | External acknowledge, one cycle per request |
| mem_rdata | input | DATA_W | External read word, valid with `mem_ack` |

## Verification
The external memory model is run with acknowledge latencies of one, two, three and four cycles. These latencies tell apart a controller that waits for each acknowledge from one that relies on a fixed timing. Client traffic is tried as isolated read-after-write pairs, back-to-back writes to several lines, and a sweep that writes and reads every line. The sweep shows whether index decode and the round-robin writer cover the whole window. Targeted patterns cover the remaining cases: a write timed to land while its own line is being written back, which exposes a dirty flag cleared too early; requests made during a drain, which must leave no trace; and an idle stretch with a clean array, in which no external request may appear.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [0:0] {PH_FILL, PH_RUN} phase_t;
endpackage

// File: rtl/wbc_store.sv
module wbc_store #(
   parameter int DATA_W = 16,
   parameter int LINES  = 8,
   parameter int IDX_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          wr_mark,
   input  logic                          clr_en,
   input  logic [IDX_W-1:0]              clr_idx,
   output logic [LINES-1:0][DATA_W-1:0]  rows,
   output logic [LINES-1:0]              dirty
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [DATA_W-1:0] q;
      logic              d;
      logic              hit_w;
      logic              hit_c;
      assign hit_w = wr_en && (wr_idx == IDX_W'(i));
      assign hit_c = clr_en && (clr_idx == IDX_W'(i));
      always_ff @(posedge clk) begin
         if (hit_w) q <= wr_data;
      end
      always_ff @(posedge clk) begin
         if (rst)                  d <= 1'b0;
         else if (hit_w && wr_mark) d <= 1'b1;
         else if (hit_c)           d <= 1'b0;
      end
      assign rows[i]  = q;
      assign dirty[i] = d;
   end

   // R8: a fresh client mark beats a write-back clear on the same line
   a_r8_mark_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mark && clr_en && wr_idx == clr_idx) |=> dirty[$past(wr_idx)]);
endmodule

// File: rtl/wbc_scan.sv
module wbc_scan #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (rst)       ptr <= '0;
      else if (step) ptr <= ptr + IDX_W'(1);
   end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl import wbc_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int LINES  = 8,
   parameter int IDX_W  = 3,
   parameter int MEM_AW = 12,
   parameter int BASE   = 256
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          drain,
   output logic                          busy,
   output logic                          drain_done,
   input  logic                          cl_req,
   input  logic                          cl_we,
   input  logic [IDX_W-1:0]              cl_idx,
   input  logic [DATA_W-1:0]             cl_wdata,
   output logic                          cl_rvalid,
   output logic [DATA_W-1:0]             cl_rdata,
   input  logic [LINES-1:0][DATA_W-1:0]  rows,
   input  logic [LINES-1:0]              dirty,
   input  logic [IDX_W-1:0]              scan_ptr,
   output logic                          scan_step,
   output logic                          st_wr_en,
   output logic [IDX_W-1:0]              st_wr_idx,
   output logic [DATA_W-1:0]             st_wr_data,
   output logic                          st_wr_mark,
   output logic                          st_clr_en,
   output logic [IDX_W-1:0]              st_clr_idx,
   output logic                          ext_req,
   output logic                          ext_we,
   output logic [MEM_AW-1:0]             ext_addr,
   output logic [DATA_W-1:0]             ext_wdata,
   input  logic                          ext_ack,
   input  logic [DATA_W-1:0]             ext_rdata
);
   localparam logic [MEM_AW-1:0] BASE_V = MEM_AW'(BASE);
   localparam logic [IDX_W-1:0]  LAST_I = IDX_W'(LINES - 1);

   phase_t           phase;
   logic [IDX_W-1:0] fill_idx;
   logic [IDX_W-1:0] wb_idx;
   logic             wb_busy;
   logic             wb_again;
   logic             filling;
   logic             cl_go;
   logic             cl_wr;
   logic             cl_hits_wb;
   logic             issue;

   assign filling = (phase == PH_FILL);
   assign busy    = filling | drain;

   always_comb begin
      cl_go      = cl_req && !busy;
      cl_wr      = cl_go && cl_we;
      cl_hits_wb = cl_wr && (cl_idx == wb_idx);
      issue      = !filling && !wb_busy && dirty[scan_ptr];
      scan_step  = !filling && !wb_busy;
      st_wr_en   = filling ? ext_ack : cl_wr;
      st_wr_idx  = filling ? fill_idx : cl_idx;
      st_wr_data = filling ? ext_rdata : cl_wdata;
      st_wr_mark = !filling;
      st_clr_en  = wb_busy && ext_ack && !wb_again;
      st_clr_idx = wb_idx;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase      <= PH_FILL;
         fill_idx   <= '0;
         wb_idx     <= '0;
         wb_busy    <= 1'b0;
         wb_again   <= 1'b0;
         ext_req    <= 1'b0;
         ext_we     <= 1'b0;
         ext_addr   <= BASE_V;
         ext_wdata  <= '0;
         cl_rvalid  <= 1'b0;
         cl_rdata   <= '0;
         drain_done <= 1'b0;
      end else begin
         cl_rvalid  <= cl_go && !cl_we;
         if (cl_go && !cl_we) cl_rdata <= rows[cl_idx];
         drain_done <= drain && (drain_done || (!filling && dirty == '0));
         if (filling) begin
            if (ext_ack) begin
               if (fill_idx == LAST_I) begin
                  phase   <= PH_RUN;
                  ext_req <= 1'b0;
               end else begin
                  fill_idx <= fill_idx + IDX_W'(1);
                  ext_addr <= BASE_V + MEM_AW'(fill_idx) + MEM_AW'(1);
               end
            end else begin
               ext_req  <= 1'b1;
               ext_addr <= BASE_V + MEM_AW'(fill_idx);
            end
         end else if (wb_busy) begin
            if (cl_hits_wb) wb_again <= 1'b1;
            if (ext_ack) begin
               wb_busy <= 1'b0;
               ext_req <= 1'b0;
            end
         end else if (issue) begin
            wb_busy   <= 1'b1;
            wb_idx    <= scan_ptr;
            wb_again  <= cl_wr && (cl_idx == scan_ptr);
            ext_req   <= 1'b1;
            ext_we    <= 1'b1;
            ext_addr  <= BASE_V + MEM_AW'(scan_ptr);
            ext_wdata <= rows[scan_ptr];
         end
      end
   end

   a_r1_no_write_in_fill: assert property (@(posedge clk) disable iff (rst)
      filling |-> !(ext_req && ext_we));
   a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
      cl_rvalid |-> $past(cl_req && !cl_we && !busy));
   a_r5_hold_request: assert property (@(posedge clk) disable iff (rst)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata)));
   a_r6_done_means_clean: assert property (@(posedge clk) disable iff (rst)
      drain_done |-> (dirty == '0));
   a_r7_done_drops: assert property (@(posedge clk) disable iff (rst)
      !drain |=> !drain_done);
   a_r10_quiet_when_clean: assert property (@(posedge clk) disable iff (rst)
      (!filling && !wb_busy && dirty == '0) |=> !ext_req);
endmodule

// File: rtl/wb_line_cache.sv
module wb_line_cache #(
   parameter int DATA_W = 16,
   parameter int LINES  = 8,
   parameter int MEM_AW = 12,
   parameter int BASE   = 256,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              drain,
   output logic              busy,
   output logic              drain_done,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_rvalid,
   output logic [DATA_W-1:0] host_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (BASE < 0 || BASE + LINES > (1 << MEM_AW)) begin : g_bad_window
      $error("window BASE..BASE+LINES-1 does not fit in MEM_AW address bits");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [LINES-1:0][DATA_W-1:0] rows;
   logic [LINES-1:0]             dirty;
   logic [IDX_W-1:0]             scan_ptr;
   logic                         scan_step;
   logic                         st_wr_en;
   logic [IDX_W-1:0]             st_wr_idx;
   logic [DATA_W-1:0]            st_wr_data;
   logic                         st_wr_mark;
   logic                         st_clr_en;
   logic [IDX_W-1:0]             st_clr_idx;

   wbc_store #(.DATA_W(DATA_W), .LINES(LINES), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst(rst),
      .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_data(st_wr_data), .wr_mark(st_wr_mark),
      .clr_en(st_clr_en), .clr_idx(st_clr_idx),
      .rows(rows), .dirty(dirty)
   );

   wbc_scan #(.IDX_W(IDX_W)) u_scan (
      .clk(clk), .rst(rst), .step(scan_step), .ptr(scan_ptr)
   );

   wbc_ctrl #(.DATA_W(DATA_W), .LINES(LINES), .IDX_W(IDX_W), .MEM_AW(MEM_AW), .BASE(BASE)) u_ctrl (
      .clk(clk), .rst(rst), .drain(drain), .busy(busy), .drain_done(drain_done),
      .cl_req(host_req), .cl_we(host_we), .cl_idx(host_idx), .cl_wdata(host_wdata),
      .cl_rvalid(host_rvalid), .cl_rdata(host_rdata),
      .rows(rows), .dirty(dirty), .scan_ptr(scan_ptr), .scan_step(scan_step),
      .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_data(st_wr_data), .st_wr_mark(st_wr_mark),
      .st_clr_en(st_clr_en), .st_clr_idx(st_clr_idx),
      .ext_req(mem_req), .ext_we(mem_we), .ext_addr(mem_addr), .ext_wdata(mem_wdata),
      .ext_ack(mem_ack), .ext_rdata(mem_rdata)
   );
endmodule

// File: tb/tb_wb_line_cache.sv
module tb_wb_line_cache;
   localparam int DW = 16;
   localparam int NL = 8;
   localparam int AW = 12;
   localparam int BS = 256;
   localparam int IW = $clog2(NL);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst = 1'b1, drain = 1'b0;
   logic          busy, drain_done;
   logic          host_req = 1'b0, host_we = 1'b0;
   logic [IW-1:0] host_idx = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          host_rvalid;
   logic [DW-1:0] host_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   wb_line_cache #(.DATA_W(DW), .LINES(NL), .MEM_AW(AW), .BASE(BS)) dut (
      .clk(clk), .rst(rst), .drain(drain), .busy(busy), .drain_done(drain_done),
      .host_req(host_req), .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_cmp = 0, n_bad = 0;
   logic [DW-1:0] emem [NL];
   logic [DW-1:0] sh   [NL];
   int ext_lat = 2, wait_cnt = 0, fills_done = 0, fill_seen = 0, wb_done = 0;
   bit ack_we = 1'b0, pbusy = 1'b1, pdone = 1'b0, ended = 1'b0;
   string tag = "R2";

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // external memory model: acknowledges after ext_lat cycles of a held request
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rst) begin
            mem_ack = 1'b0; wait_cnt = 0;
         end else if (mem_ack) begin
            mem_ack = 1'b0; wait_cnt = 0;
            if (ack_we) wb_done++; else fills_done++;
         end else if (mem_req) begin
            wait_cnt++;
            if (wait_cnt >= ext_lat) begin
               int a;
               a = int'(mem_addr) - BS;
               mem_ack = 1'b1;
               ack_we  = mem_we;
               if (a < 0 || a >= NL) chk(0, "R1", "address outside window", mem_addr, BS);
               else if (mem_we) begin
                  if (fills_done < NL) chk(0, "R1", "write before preload end", mem_addr, 0);
                  emem[a] = mem_wdata;
               end else begin
                  chk(a == fill_seen, "R1", "preload order", mem_addr, BS + fill_seen);
                  mem_rdata = emem[a];
                  fill_seen++;
               end
            end
         end
      end
   end

   // reference comparison on every clock, sampled 3 ns after the edge
   initial begin
      forever begin
         @(posedge clk); #3;
         if (rst) begin
            chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
            chk(host_rvalid == 1'b0, "R1", "rvalid in reset", host_rvalid, 0);
            chk(drain_done == 1'b0, "R1", "drain_done in reset", drain_done, 0);
            chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
            pbusy = 1'b1; pdone = 1'b0;
         end else begin
            bit acc, exp_rv, exp_busy;
            exp_busy = (fills_done < NL) || drain;
            chk(busy == exp_busy, (fills_done < NL) ? "R1" : "R6", "busy", busy, exp_busy);
            acc    = host_req && !pbusy;
            exp_rv = acc && !host_we;
            chk(host_rvalid == exp_rv, tag, "read valid", host_rvalid, exp_rv);
            if (exp_rv && host_rvalid)
               chk(host_rdata == sh[host_idx], tag, "read data", host_rdata, sh[host_idx]);
            if (acc && host_we) sh[host_idx] = host_wdata;
            if (!drain && drain_done) chk(0, "R7", "done without drain", drain_done, 0);
            if (drain && pdone && !drain_done) chk(0, "R7", "done dropped while draining", 0, 1);
            if (drain_done && !pdone)
               for (int i = 0; i < NL; i++)
                  chk(emem[i] == sh[i], "R6", "external word at drain done", emem[i], sh[i]);
            pbusy = busy; pdone = drain_done;
         end
      end
   end

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   task automatic op(bit we, int idx, logic [DW-1:0] d);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_idx = IW'(idx); host_wdata = d;
      @(negedge clk);
      host_req = 1'b0;
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 500 && busy; k++) @(negedge clk);
   endtask

   task automatic do_drain();
      @(negedge clk); drain = 1'b1;
      for (int k = 0; k < 500 && !drain_done; k++) @(negedge clk);
      chk(drain_done == 1'b1, "R6", "drain completes", drain_done, 1);
      repeat (5) @(negedge clk);
      chk(drain_done == 1'b1, "R7", "done held while drain high", drain_done, 1);
      drain = 1'b0;
      @(negedge clk);
      chk(drain_done == 1'b0, "R7", "done low after drain", drain_done, 0);
   endtask

   initial begin
      for (int i = 0; i < NL; i++) begin
         emem[i] = DW'(16'hA500 + i * 16'h0111);
         sh[i]   = emem[i];
      end
      repeat (4) @(negedge clk);
      rst = 1'b0;
      wait_ready();
      chk(fills_done == NL, "R2", "preload count at busy low", fills_done, NL);

      tag = "R2";
      for (int i = 0; i < NL; i++) op(1'b0, i, '0);

      tag = "R3";
      op(1'b1, 2, 16'h1234); op(1'b0, 2, '0);
      op(1'b1, 5, 16'h5555); op(1'b1, 6, 16'h6666);
      op(1'b0, 5, '0); op(1'b0, 6, '0);

      repeat (40) @(negedge clk);
      chk(emem[2] == 16'h1234, "R4", "background write line 2", emem[2], 16'h1234);
      chk(emem[5] == 16'h5555, "R4", "background write line 5", emem[5], 16'h5555);
      chk(emem[6] == 16'h6666, "R4", "background write line 6", emem[6], 16'h6666);

      tag = "R8";
      ext_lat = 4;
      op(1'b1, 3, 16'hAAAA);
      for (int k = 0; k < 100; k++) begin
         @(posedge clk); #3;
         if (mem_req && mem_we && mem_addr == AW'(BS + 3)) break;
      end
      op(1'b1, 3, 16'hBBBB);
      repeat (60) @(negedge clk);
      chk(emem[3] == 16'hBBBB, "R8", "newer word written again", emem[3], 16'hBBBB);

      tag = "R6";
      ext_lat = 3;
      op(1'b1, 0, 16'h0F0F); op(1'b1, 1, 16'h1E1E); op(1'b1, 7, 16'h7777); op(1'b1, 0, 16'h0C0C);
      do_drain();

      tag = "R9";
      @(negedge clk); drain = 1'b1;
      op(1'b1, 4, 16'hDEAD);
      op(1'b0, 4, '0);
      repeat (10) @(negedge clk);
      drain = 1'b0;
      repeat (2) @(negedge clk);
      op(1'b0, 4, '0);
      chk(sh[4] != 16'hDEAD, "R9", "stalled write left line unchanged", sh[4], emem[4]);

      begin
         int wb0, reqs;
         wb0 = wb_done; reqs = 0;
         for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (mem_req) reqs++;
         end
         chk(reqs == 0, "R10", "requests while clean", reqs, 0);
         chk(wb_done == wb0, "R10", "write-backs while clean", wb_done, wb0);
      end

      tag = "R3";
      ext_lat = 1;
      for (int i = 0; i < NL; i++) op(1'b1, i, DW'(16'h3000 + i * 16'h0103));
      for (int i = NL - 1; i >= 0; i--) op(1'b0, i, '0);
      tag = "R6";
      do_drain();
      for (int i = 0; i < NL; i++)
         chk(emem[i] == sh[i], "R4", "external word after sweep", emem[i], sh[i]);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule